// File: doc/BRIEF.md
# Gated Clock Selector and Divider

This block derives one peripheral clock from a set of candidate source clocks. It picks one source by index, divides it by a programmable integer and passes the result through a run/stop gate. All input clocks are sampled by the block clock, and the output is a registered signal in that domain. Each source's high and low phases must therefore last at least two block-clock cycles.

Software programs the block through four small registers. Address 0 holds the source index. Address 1 holds the divisor minus one. Address 2 holds the control bits: bit 0 is the stop bit and bit 1 is the apply-enable bit. Address 3 is read-only, and its bit 0 is the busy flag.

A new index or divisor is stored at once but reaches the output only while apply-enable is set. The switch itself follows a fixed sequence. The old clock is first drained to a low level. The new source is then seen to rise twice. Finally the output is released during a low phase of the new source. Busy stays set from the request until this sequence is complete.

Top module: `pclk_gen`

## Requirements
- R1: The divider field at address 1 holds the divisor minus one. Field value k makes one output period last k+1 periods of the selected source.
- R2: Bit 0 of address 2 set to 1 stops the output at a low level, and set to 0 lets it run. Stopping never shortens a high phase that has already started.
- R3: A changed source index or divisor reaches the output only while bit 1 of address 2 is 1.
- R4: Bit 0 of address 3 reads 1 from the cycle after the write that makes the stored settings differ from the applied ones while apply-enable is 1. It returns to 0 once the new setting drives the output.
- R5: The source index at address 0 chooses which element of src_clk is divided.
- R6: A source or divisor change produces no high or low phase shorter than the shorter legal phase of the old and new settings.
- R7: For an even divisor the output has equal high and low phases. For an odd divisor of 3 or more, the high phase is one source period shorter than the low phase. A divisor of 1 follows the source's own waveform.
- R8: Writes to addresses 0 and 1 while apply-enable is 0 are stored and read back unchanged.
- R9: An index at or above the number of sources gives a constant low output, and busy still clears.
- R10: After reset, address 0 reads 0, address 1 reads 0, address 2 reads 1 (stopped, apply-enable 0), address 3 reads 0 and the output is low.
- R11: With a single source the index field has no effect: that source is always divided, and changing the index raises no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all sampling and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | N_SRC | Candidate source clocks, sampled by clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
The bench builds two copies of the block. The main copy has three sources and a 2-bit index, so index 3 is out of range and the dead-clock case of R9 can be reached. Its 4-bit divider field reaches both even and odd divisors. The second copy has one source, which brings the ignored-index behaviour of R11 within reach. Source periods of 8, 12 and 20 block cycles make every legal phase length distinct. This lets a runt pulse during a switch or a stop be told apart from a legal phase.

// File: rtl/pclk_pkg.sv
`timescale 1ns/1ps
package pclk_pkg;
  // register addresses
  localparam logic [1:0] REG_SEL  = 2'd0;
  localparam logic [1:0] REG_DIV  = 2'd1;
  localparam logic [1:0] REG_CTL  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;
  // control bit positions
  localparam int CTL_STOP_BIT  = 0;
  localparam int CTL_APPLY_BIT = 1;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DRAIN = 2'd1,
    SW_SYNC  = 2'd2
  } sw_state_e;

  // number of source periods the output stays high for a divider field value
  function automatic int unsigned hi_cycles(input int unsigned field);
    int unsigned divisor;
    divisor = field + 1;
    return divisor / 2;
  endfunction
endpackage

// File: rtl/pclk_sync.sv
`timescale 1ns/1ps
module pclk_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/pclk_div.sv
`timescale 1ns/1ps
module pclk_div import pclk_pkg::*; #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             src_lvl,
  input  logic             src_rise,
  input  logic [DIV_W-1:0] div_field,
  output logic             div_out
);
  localparam int HW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_nx;
  logic [HW-1:0]    hi_n;
  logic             q;

  assign hi_n   = HW'(hi_cycles(32'(div_field)));
  assign cnt_nx = (cnt_q >= div_field) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q     <= 1'b0;
    end else if (clr) begin
      cnt_q <= div_field;            // first source rise after release starts a high phase
      q     <= 1'b0;
    end else if (src_rise) begin
      cnt_q <= cnt_nx;
      q     <= ({1'b0, cnt_nx} < hi_n);
    end
  end

  assign div_out = !clr && ((div_field == '0) ? src_lvl : q);

  // R1: the period counter never passes the programmed field while running
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt_q <= div_field));
endmodule

// File: rtl/pclk_switch.sv
`timescale 1ns/1ps
module pclk_switch import pclk_pkg::*; #(
  parameter int N_SRC = 3,
  parameter int SEL_W = 2,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply_en,
  input  logic [SEL_W-1:0] want_sel,
  input  logic [DIV_W-1:0] want_div,
  input  logic             out_low,
  input  logic             new_rise,
  input  logic             new_lvl,
  output logic [SEL_W-1:0] act_sel,
  output logic [DIV_W-1:0] act_div,
  output logic             hold,
  output logic             busy
);
  sw_state_e  state_q;
  logic [1:0] edges_q;
  logic       pending;
  logic       want_valid;

  assign pending    = apply_en && ((want_sel != act_sel) || (want_div != act_div));
  assign want_valid = int'(want_sel) < N_SRC;
  assign hold       = (state_q == SW_SYNC);
  assign busy       = pending || (state_q != SW_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      edges_q <= '0;
      act_sel <= '0;
      act_div <= '0;
    end else begin
      case (state_q)
        SW_IDLE: if (pending) state_q <= SW_DRAIN;
        SW_DRAIN: begin
          if (!pending) begin
            state_q <= SW_IDLE;
          end else if (out_low) begin
            act_sel <= want_sel;
            act_div <= want_div;
            edges_q <= '0;
            state_q <= want_valid ? SW_SYNC : SW_IDLE;
          end
        end
        SW_SYNC: begin
          if (new_rise && edges_q != 2'd2) edges_q <= edges_q + 2'd1;
          if (edges_q == 2'd2 && !new_lvl) state_q <= SW_IDLE;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  // R3: applied settings move only while apply-enable is set
  a_r3_hold_without_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_en |=> ($stable(act_sel) && $stable(act_div)));

  // R6: release happens after two new-source rises and during a low phase
  a_r6_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (!$past(new_lvl) && $past(edges_q) == 2'd2));
endmodule

// File: rtl/pclk_gen.sv
`timescale 1ns/1ps
module pclk_gen import pclk_pkg::*; #(
  parameter int N_SRC = 3,
  parameter int SEL_W = 2,
  parameter int DIV_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_clk,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             clk_out
);
  logic [SEL_W-1:0] sel_q, want_sel, act_sel;
  logic [DIV_W-1:0] div_q, act_div;
  logic             stop_q, apply_q, en_q;
  logic [N_SRC-1:0] s_lvl, s_rise;
  logic             lvl_sel, rise_sel, sel_valid;
  logic             sw_hold, busy, div_clr, div_out;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      div_q   <= '0;
      stop_q  <= 1'b1;
      apply_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        REG_SEL: sel_q <= reg_wdata[SEL_W-1:0];
        REG_DIV: div_q <= reg_wdata[DIV_W-1:0];
        REG_CTL: begin
          stop_q  <= reg_wdata[CTL_STOP_BIT];
          apply_q <= reg_wdata[CTL_APPLY_BIT];
        end
        default: ;
      endcase
    end
  end

  generate
    if (N_SRC == 1) begin : g_single
      assign want_sel = '0;
    end else begin : g_multi
      assign want_sel = sel_q;
    end
  endgenerate

  pclk_sync #(.N(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(src_clk), .lvl(s_lvl), .rise(s_rise)
  );

  always_comb begin
    lvl_sel   = 1'b0;
    rise_sel  = 1'b0;
    sel_valid = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (act_sel == SEL_W'(i)) begin
        lvl_sel   = s_lvl[i];
        rise_sel  = s_rise[i];
        sel_valid = 1'b1;
      end
    end
  end

  pclk_switch #(.N_SRC(N_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_switch (
    .clk(clk), .rst_n(rst_n), .apply_en(apply_q),
    .want_sel(want_sel), .want_div(div_q),
    .out_low(!div_out), .new_rise(rise_sel), .new_lvl(lvl_sel),
    .act_sel(act_sel), .act_div(act_div), .hold(sw_hold), .busy(busy)
  );

  assign div_clr = sw_hold || !sel_valid;

  pclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .src_lvl(lvl_sel),
    .src_rise(rise_sel), .div_field(act_div), .div_out(div_out)
  );

  // gate follows the stop bit only while the divided clock is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      if (!div_out) en_q <= !stop_q;
      clk_out <= div_out && en_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_SEL: reg_rdata = DW'(sel_q);
      REG_DIV: reg_rdata = DW'(div_q);
      REG_CTL: begin
        reg_rdata[CTL_STOP_BIT]  = stop_q;
        reg_rdata[CTL_APPLY_BIT] = apply_q;
      end
      default: reg_rdata[0] = busy;
    endcase
  end

  // R2: when the gate closes the output is already low
  a_r2_stop_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> !clk_out);

  // R9: an out-of-range index keeps the output low
  a_r9_dead_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_valid && $past(!sel_valid)) |-> !clk_out);
endmodule

// File: tb/tb_pclk_gen.sv
`timescale 1ns/1ps
module tb_pclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] src = 3'b000;
  logic       we0 = 1'b0, we1 = 1'b0;
  logic [1:0] ad0 = 2'd0, ad1 = 2'd0;
  logic [7:0] wd0 = 8'd0, wd1 = 8'd0;
  logic [7:0] rd0, rd1;
  logic       co0, co1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  initial begin #3; forever #40  src[0] = ~src[0]; end
  initial begin #3; forever #60  src[1] = ~src[1]; end
  initial begin #3; forever #100 src[2] = ~src[2]; end

  pclk_gen #(.N_SRC(3), .SEL_W(2), .DIV_W(4), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_clk(src), .reg_we(we0), .reg_addr(ad0),
    .reg_wdata(wd0), .reg_rdata(rd0), .clk_out(co0));

  pclk_gen #(.N_SRC(1), .SEL_W(2), .DIV_W(4), .DW(8)) dut_one (
    .clk(clk), .rst_n(rst_n), .src_clk(src[0:0]), .reg_we(we1), .reg_addr(ad1),
    .reg_wdata(wd1), .reg_rdata(rd1), .clk_out(co1));

  // run-length monitor on the main output
  bit run_prev = 1'b0;
  bit run_counted = 1'b0;
  bit mon_en = 1'b0;
  int run_len = 0;
  int min_hi = 1000000;
  int min_lo = 1000000;
  always @(negedge clk) begin
    if (co0 == run_prev) run_len++;
    else begin
      if (run_counted) begin
        if (run_prev && run_len < min_hi) min_hi = run_len;
        if (!run_prev && run_len < min_lo) min_lo = run_len;
      end
      run_prev = co0;
      run_len = 1;
      run_counted = mon_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit one, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    if (one) begin we1 = 1'b1; ad1 = a; wd1 = d; end
    else     begin we0 = 1'b1; ad0 = a; wd0 = d; end
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input bit one, input logic [1:0] a, output int d);
    @(negedge clk);
    if (one) ad1 = a; else ad0 = a;
    #1 d = one ? int'(rd1) : int'(rd0);
  endtask

  function automatic bit outv(input bit one);
    return one ? co1 : co0;
  endfunction

  task automatic wait_level(input bit one, input bit lv);
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (outv(one) == lv) return;
    end
  endtask

  task automatic measure(input bit one, output int hi, output int lo);
    wait_level(one, 1'b0); wait_level(one, 1'b1);
    wait_level(one, 1'b0); wait_level(one, 1'b1);
    hi = 0; lo = 0;
    while (outv(one) == 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
    while (outv(one) == 1'b0 && lo < 2000) begin lo++; @(negedge clk); end
  endtask

  task automatic wait_idle(input bit one, input string req);
    int s;
    s = 1;
    for (int g = 0; g < 500 && s != 0; g++) rd(one, 2'd3, s);
    check(req, s & 1, 0);
  endtask

  task automatic low_for(input bit one, input int n, input string req);
    int highs;
    highs = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (outv(one)) highs++; end
    check(req, highs, 0);
  endtask

  // expected phases from a field value and a source period
  task automatic expect_wave(input bit one, input int field, input int per, input string req);
    int hi, lo, d, eh, el;
    d = field + 1;
    if (d == 1) begin eh = per / 2; el = per / 2; end
    else begin eh = (d / 2) * per; el = (d - d / 2) * per; end
    measure(one, hi, lo);
    check({req, " high"}, hi, eh);
    check({req, " low"}, lo, el);
  endtask

  task automatic t_reset;
    int v;
    rd(0, 2'd0, v); check("R10 sel reset", v, 0);
    rd(0, 2'd1, v); check("R10 div reset", v, 0);
    rd(0, 2'd2, v); check("R10 ctl reset", v, 1);
    rd(0, 2'd3, v); check("R10 busy reset", v, 0);
    low_for(0, 60, "R10 R2 output held low when stopped");
  endtask

  task automatic t_run;
    wr(0, 2'd2, 8'h00);
    expect_wave(0, 0, 8, "R2 R5 R7 run src0 divide by 1");
  endtask

  task automatic t_div_even;
    wr(0, 2'd2, 8'h02);
    wr(0, 2'd1, 8'd3);
    wait_idle(0, "R4 busy clears after divisor change");
    wr(0, 2'd2, 8'h00);
    expect_wave(0, 3, 8, "R1 R7 divide by 4");
  endtask

  task automatic t_div_odd;
    wr(0, 2'd2, 8'h02);
    wr(0, 2'd1, 8'd2);
    wait_idle(0, "R4 busy clears");
    wr(0, 2'd2, 8'h00);
    expect_wave(0, 2, 8, "R1 R7 divide by 3");
  endtask

  task automatic t_stored;
    int v;
    wr(0, 2'd1, 8'd0);
    rd(0, 2'd1, v); check("R8 stored divider reads back", v, 0);
    expect_wave(0, 2, 8, "R3 no effect without apply");
    wr(0, 2'd2, 8'h02);
    rd(0, 2'd3, v); check("R4 busy on apply", v & 1, 1);
    wait_idle(0, "R4 busy clears");
    wr(0, 2'd2, 8'h00);
    expect_wave(0, 0, 8, "R3 applied after apply-enable");
  endtask

  task automatic t_switch;
    int v;
    wr(0, 2'd2, 8'h02);
    min_hi = 1000000; min_lo = 1000000; mon_en = 1'b1;
    wr(0, 2'd0, 8'd2);
    rd(0, 2'd3, v); check("R4 busy after source write", v & 1, 1);
    wait_idle(0, "R4 busy clears after switch");
    expect_wave(0, 0, 20, "R5 source 2 selected");
    mon_en = 1'b0;
    wr(0, 2'd2, 8'h00);
    check("R6 no short high in switch", (min_hi >= 4) ? 1 : 0, 1);
    check("R6 no short low in switch", (min_lo >= 4) ? 1 : 0, 1);
  endtask

  task automatic t_range;
    wr(0, 2'd2, 8'h02);
    wr(0, 2'd0, 8'd3);
    wait_idle(0, "R9 busy clears on invalid index");
    low_for(0, 100, "R9 invalid index dead output");
    wr(0, 2'd0, 8'd1);
    wait_idle(0, "R4 busy clears");
    wr(0, 2'd2, 8'h00);
    expect_wave(0, 0, 12, "R5 source 1 selected");
  endtask

  task automatic t_stop;
    wr(0, 2'd2, 8'h02);
    wr(0, 2'd1, 8'd1);
    wait_idle(0, "R4 busy clears");
    wr(0, 2'd2, 8'h00);
    expect_wave(0, 1, 12, "R7 divide by 2 even duty");
    min_hi = 1000000; mon_en = 1'b1;
    wait_level(0, 1'b1);
    repeat (3) @(negedge clk);
    wr(0, 2'd2, 8'h01);
    repeat (40) @(negedge clk);
    low_for(0, 100, "R2 stop holds output low");
    mon_en = 1'b0;
    check("R2 stop does not cut a high phase", min_hi, 12);
  endtask

  task automatic t_single;
    int v;
    wr(1, 2'd2, 8'h02);
    wr(1, 2'd0, 8'd2);
    rd(1, 2'd3, v); check("R11 index change gives no busy", v & 1, 0);
    wr(1, 2'd2, 8'h00);
    expect_wave(1, 0, 8, "R11 single source always used");
  endtask

  initial begin
    #(1_000_000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_run;
    t_div_even;
    t_div_odd;
    t_stored;
    t_switch;
    t_range;
    t_stop;
    t_single;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule